// File: doc/BRIEF.md
# Constant On-Time Switching Timer

This block drives the high-side and low-side gate enables of a synchronous buck converter that uses constant on-time control. No fixed clock sets the switching period. A high-side pulse is launched when the feedback comparator asks for energy, and that pulse lasts a programmed number of cycles. A guaranteed low interval follows it before the next pulse may start. Both gates are held off for a short dead time whenever one of them hands over to the other. All timing is counted in cycles of a fast system clock.

A two-bit mode input selects one of three light-load behaviours. In continuous mode the low-side stays on until the next pulse. In skip mode the low-side is cut when the zero-crossing flag rises, so the inductor current cannot reverse. In ultrasonic skip mode the block also forces a pulse whenever the time since the last pulse start reaches a window, which keeps the switching rate above the audio band. The run input from the power sequencer gates everything: when it falls, both gates drop in the same cycle and all timers are cleared.

Top module: `cotTimer`

## Requirements
- R1: A pulse start needs `curLimit` low and the minimum off-time elapsed, together with either `errHigh` high or a forced start (R6). While `curLimit` is high no pulse starts. In modes 2'b00 and 2'b01 no pulse starts while `errHigh` is low.
- R2: After `hsGate` falls it stays low for at least MIN_OFF cycles. With `errHigh` held high and `curLimit` low, the low interval is exactly MIN_OFF+DEAD+1 cycles.
- R3: A high-side pulse lasts `onCount` cycles, with 0 treated as 1. The count is captured when the pulse start is decided, so later changes to `onCount` do not affect a pulse already under way.
- R4: Between `hsGate` falling and `lsGate` rising, both gates are low for exactly DEAD cycles. When a pulse starts while the low-side is on, both gates are also low for exactly DEAD cycles between `lsGate` falling and `hsGate` rising.
- R5: In mode 2'b01 or 2'b1x, `zeroCross` high while the low-side is on (and no start is due) drops `lsGate` on the next cycle, and it stays low until the next pulse. In mode 2'b00 `zeroCross` is ignored and `lsGate` stays high.
- R6: In mode 2'b1x, a pulse is forced once US_WIN cycles have passed since the last pulse start, still subject to R1's current-limit and off-time conditions. With `errHigh` low, successive `hsGate` rises are then US_WIN+1 cycles apart.
- R7: With `run` low, both gates are low in that same cycle and every timer is cleared. After `run` returns high, the first pulse has the full programmed width.
- R8: `hsGate` and `lsGate` are never high in the same cycle.
- R9: After reset both gate enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that all timing is counted in |
| rstN | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enable from the power sequencer; low forces both gates off and clears the timers |
| errHigh | input | 1 | Feedback comparator says the output is below target |
| curLimit | input | 1 | Valley current-limit flag; high blocks new pulses |
| zeroCross | input | 1 | Inductor current has reached zero |
| mode | input | 2 | 2'b00 continuous, 2'b01 skip, 2'b1x skip with ultrasonic floor |
| onCount | input | CNT_W | High-side pulse width in clock cycles |
| hsGate | output | 1 | High-side gate enable |
| lsGate | output | 1 | Low-side gate enable |

## Verification
The assertions assume that every input is synchronous to `clk` and that MIN_OFF exceeds DEAD, so the low-side is always reached before a new start can be decided. The skip-cut and run-clear properties also assume that `mode` holds steady around a zero-crossing event. The stimulus changes inputs only one nanosecond after a clock edge, uses parameters with MIN_OFF well above DEAD, and switches `mode` only while no gate handover is in progress.

// File: rtl/cotPkg.sv
package cotPkg;
  typedef enum logic [2:0] {
    ST_OFF  = 3'd0,
    ST_DTH  = 3'd1,
    ST_HSON = 3'd2,
    ST_DTL  = 3'd3,
    ST_LSON = 3'd4
  } cotState_e;

  typedef struct packed {
    logic clrAll;
    logic start;
    logic loadDead;
    logic loadOn;
    logic loadMinOff;
  } cotStrobe_t;
endpackage

// File: rtl/cotCounters.sv
module cotCounters
  import cotPkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_OFF = 80,
  parameter int DEAD    = 6,
  parameter int US_WIN  = 5400
) (
  input  logic             clk,
  input  logic             rstN,
  input  cotStrobe_t       strb,
  input  logic [CNT_W-1:0] onCount,
  output logic             phaseDone,
  output logic             minOffDone,
  output logic             usExpired
);
  localparam int DEAD_W = $clog2(DEAD + 1);
  localparam int PH_W   = (CNT_W > DEAD_W) ? CNT_W : DEAD_W;
  localparam int MO_W   = $clog2(MIN_OFF + 1);
  localparam int US_W   = $clog2(US_WIN + 1);

  logic [CNT_W-1:0] onLat;
  logic [PH_W-1:0]  phaseCnt;
  logic [MO_W-1:0]  minOffCnt;
  logic [US_W-1:0]  usCnt;

  // pulse width captured when the start is decided
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              onLat <= CNT_W'(1);
    else if (strb.start)    onLat <= (onCount == '0) ? CNT_W'(1) : onCount;
  end

  // shared phase timer: dead time and on-time
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 phaseCnt <= '0;
    else if (strb.clrAll)      phaseCnt <= '0;
    else if (strb.loadDead)    phaseCnt <= PH_W'(DEAD - 1);
    else if (strb.loadOn)      phaseCnt <= PH_W'(onLat) - PH_W'(1);
    else if (phaseCnt != '0)   phaseCnt <= phaseCnt - PH_W'(1);
  end

  // minimum off-time one-shot
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 minOffCnt <= '0;
    else if (strb.clrAll)      minOffCnt <= '0;
    else if (strb.loadMinOff)  minOffCnt <= MO_W'(MIN_OFF);
    else if (minOffCnt != '0)  minOffCnt <= minOffCnt - MO_W'(1);
  end

  // time since last pulse start, saturating at the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        usCnt <= '0;
    else if (strb.clrAll || strb.start) usCnt <= '0;
    else if (usCnt != US_W'(US_WIN))  usCnt <= usCnt + US_W'(1);
  end

  assign phaseDone  = (phaseCnt == '0);
  assign minOffDone = (minOffCnt == '0);
  assign usExpired  = (usCnt == US_W'(US_WIN));

  assert_start_after_minoff_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |-> minOffDone);

  assert_window_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    usCnt <= US_W'(US_WIN));

  assert_minoff_reload_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadMinOff |=> (minOffCnt == MO_W'(MIN_OFF)));
endmodule

// File: rtl/cotSequencer.sv
module cotSequencer
  import cotPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       run,
  input  logic       errHigh,
  input  logic       curLimit,
  input  logic       zeroCross,
  input  logic [1:0] mode,
  input  logic       phaseDone,
  input  logic       minOffDone,
  input  logic       usExpired,
  output cotStrobe_t strb,
  output logic       hsGate,
  output logic       lsGate
);
  cotState_e state, stateNext;
  logic startOk;
  logic skipOn;

  assign skipOn  = (mode != 2'b00);
  assign startOk = (errHigh || (mode[1] && usExpired)) && !curLimit && minOffDone;

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (!run) begin
      stateNext   = ST_OFF;
      strb.clrAll = 1'b1;
    end else begin
      unique case (state)
        ST_OFF: if (startOk) begin
          strb.start = 1'b1; strb.loadDead = 1'b1; stateNext = ST_DTH;
        end
        ST_DTH: if (phaseDone) begin
          strb.loadOn = 1'b1; stateNext = ST_HSON;
        end
        ST_HSON: if (phaseDone) begin
          strb.loadDead = 1'b1; strb.loadMinOff = 1'b1; stateNext = ST_DTL;
        end
        ST_DTL: if (phaseDone) stateNext = ST_LSON;
        ST_LSON: begin
          if (startOk) begin
            strb.start = 1'b1; strb.loadDead = 1'b1; stateNext = ST_DTH;
          end else if (skipOn && zeroCross) begin
            stateNext = ST_OFF;
          end
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign hsGate = run && (state == ST_HSON);
  assign lsGate = run && (state == ST_LSON);

  assert_dead_before_hs_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> !$past(lsGate));

  assert_dead_before_ls_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lsGate) |-> !$past(hsGate));

  assert_skip_cut_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lsGate && skipOn && zeroCross && !startOk) |=> !lsGate);

  assert_fccm_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lsGate && mode == 2'b00 && !startOk) |=> (lsGate || !run));

  assert_run_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (state == ST_OFF));

  assert_blocked_by_limit_R1: assert property (@(posedge clk) disable iff (!rstN)
    (curLimit && state != ST_DTH) |=> (state != ST_DTH));
endmodule

// File: rtl/cotTimer.sv
module cotTimer
  import cotPkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int MIN_OFF = 80,
  parameter int DEAD    = 6,
  parameter int US_WIN  = 5400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             errHigh,
  input  logic             curLimit,
  input  logic             zeroCross,
  input  logic [1:0]       mode,
  input  logic [CNT_W-1:0] onCount,
  output logic             hsGate,
  output logic             lsGate
);
  cotStrobe_t strb;
  logic phaseDone, minOffDone, usExpired;

  cotSequencer i_seq (
    .clk(clk), .rstN(rstN), .run(run), .errHigh(errHigh), .curLimit(curLimit),
    .zeroCross(zeroCross), .mode(mode), .phaseDone(phaseDone),
    .minOffDone(minOffDone), .usExpired(usExpired), .strb(strb),
    .hsGate(hsGate), .lsGate(lsGate)
  );

  cotCounters #(.CNT_W(CNT_W), .MIN_OFF(MIN_OFF), .DEAD(DEAD), .US_WIN(US_WIN)) i_cnt (
    .clk(clk), .rstN(rstN), .strb(strb), .onCount(onCount),
    .phaseDone(phaseDone), .minOffDone(minOffDone), .usExpired(usExpired)
  );

  assert_gates_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hsGate) |-> !lsGate);
endmodule

// File: tb/test_cotTimer.sv
`timescale 1ns/1ps
module test_cotTimer;
  localparam int CNT_W   = 8;
  localparam int MIN_OFF = 20;
  localparam int DEAD    = 4;
  localparam int US_WIN  = 300;
  localparam int GAP     = MIN_OFF + DEAD + 1;
  localparam int VEC_N   = 4;
  // {onCount, expected width}
  localparam int VEC [0:VEC_N-1][0:1] = '{'{10, 10}, '{3, 3}, '{0, 1}, '{25, 25}};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic run = 1'b0, errHigh = 1'b0, curLimit = 1'b0, zeroCross = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [CNT_W-1:0] onCount = 8'd10;
  logic hsGate, lsGate;

  int total = 0, bad = 0;
  int cyc = 0, riseCyc = 0, lastHsFall = 0, lastLsFall = 0;
  int lastWidth = 0, lastGap = 0, lastPeriod = 0, lastDLH = 0, lastDHL = 0;
  int hsRises = 0, hsFalls = 0, overlap = 0;
  logic prevHs = 1'b0, prevLs = 1'b0;

  always #2.5 clk = ~clk;

  cotTimer #(.CNT_W(CNT_W), .MIN_OFF(MIN_OFF), .DEAD(DEAD), .US_WIN(US_WIN)) i_cotTimer (
    .clk(clk), .rstN(rstN), .run(run), .errHigh(errHigh), .curLimit(curLimit),
    .zeroCross(zeroCross), .mode(mode), .onCount(onCount),
    .hsGate(hsGate), .lsGate(lsGate)
  );

  // port-level interval monitor
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (hsGate && !prevHs) begin
      hsRises = hsRises + 1; lastPeriod = cyc - riseCyc; riseCyc = cyc;
      lastGap = cyc - lastHsFall; lastDLH = cyc - lastLsFall;
    end
    if (!hsGate && prevHs) begin
      hsFalls = hsFalls + 1; lastWidth = cyc - riseCyc; lastHsFall = cyc;
    end
    if (lsGate && !prevLs) lastDHL = cyc - lastHsFall;
    if (!lsGate && prevLs) lastLsFall = cyc;
    if (hsGate && lsGate) overlap = overlap + 1;
    prevHs = hsGate; prevLs = lsGate;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic waitRise(output bit ok);
    int s = hsRises;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (hsRises != s) begin ok = 1'b1; break; end
    end
  endtask

  task automatic waitFall(output bit ok);
    int s = hsFalls;
    ok = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk); #1;
      if (hsFalls != s) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    #(5.0 * 190000);
    total++; bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit ok;
    int snap;
    tick(5);
    rstN = 1'b1;
    tick(3);
    chk("R9 hsGate after reset", hsGate, 0);
    chk("R9 lsGate after reset", lsGate, 0);

    // table: continuous mode, errHigh held high
    run = 1'b1; errHigh = 1'b1; mode = 2'b00;
    for (int v = 0; v < VEC_N; v++) begin
      onCount = CNT_W'(VEC[v][0]);
      waitRise(ok); waitRise(ok);
      chk("R2 low interval", lastGap, GAP);
      chk("R4 ls-fall to hs-rise", lastDLH, DEAD);
      chk("R4 hs-fall to ls-rise", lastDHL, DEAD);
      waitFall(ok);
      chk("R3 pulse width", lastWidth, VEC[v][1]);
    end

    // R3: count captured at start
    onCount = 8'd12;
    waitRise(ok); waitRise(ok);
    onCount = 8'd30;
    waitFall(ok);
    chk("R3 width held while count changes", lastWidth, 12);
    waitRise(ok); waitFall(ok);
    chk("R3 new count on next pulse", lastWidth, 30);

    // continuous mode, errHigh low: low-side held, zeroCross ignored
    waitRise(ok);
    errHigh = 1'b0;
    waitFall(ok);
    tick(DEAD + 3);
    snap = hsRises;
    zeroCross = 1'b1;
    tick(5);
    chk("R5 continuous ignores zeroCross", lsGate, 1);
    chk("R1 no start without errHigh", hsRises - snap, 0);
    zeroCross = 1'b0;

    // skip mode: zeroCross cuts the low side one cycle later
    mode = 2'b01;
    tick(1);
    chk("R5 ls still on before zeroCross", lsGate, 1);
    zeroCross = 1'b1;
    tick(1);
    chk("R5 ls cut by zeroCross", lsGate, 0);
    zeroCross = 1'b0;
    tick(5);
    chk("R5 ls stays off after cut", lsGate, 0);

    // skip without ultrasonic floor: no forced pulses
    snap = hsRises;
    tick(US_WIN + 50);
    chk("R6 no forced pulse in plain skip", hsRises - snap, 0);

    // ultrasonic floor
    mode = 2'b10;
    waitRise(ok);
    chk("R6 forced pulse occurs", int'(ok), 1);
    waitRise(ok);
    chk("R6 forced period", lastPeriod, US_WIN + 1);

    // current limit blocks both requested and forced pulses
    curLimit = 1'b1; errHigh = 1'b1;
    tick(60);
    snap = hsRises;
    tick(US_WIN + 50);
    chk("R1 curLimit blocks pulses", hsRises - snap, 0);
    curLimit = 1'b0;
    waitRise(ok);
    chk("R1 pulse after curLimit clears", int'(ok), 1);

    // run low mid-pulse
    mode = 2'b00; onCount = 8'd40;
    waitRise(ok); waitRise(ok);
    tick(5);
    run = 1'b0;
    #0.5;
    chk("R7 hsGate low same cycle", hsGate, 0);
    chk("R7 lsGate low same cycle", lsGate, 0);
    tick(10);
    chk("R7 gates stay low", hsGate | lsGate, 0);
    run = 1'b1;
    waitRise(ok); waitFall(ok);
    chk("R7 full width after restart", lastWidth, 40);

    chk("R8 no overlap cycles", overlap, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule